// File: doc/BRIEF.md
# Gated Boundary-Scan Test Access Port

This block is a four-wire test access port controller with an active-low asynchronous reset. It contains the sixteen-state TAP state machine, a three-bit instruction register, a one-bit bypass register and a 32-bit identification register. It selects which register drives the serial output, and it gives an external boundary register a select level, capture, shift and update strobes, and an EXTEST indication.

Boundary-scan operation is gated by three configuration pins. The pins are sampled once, on the rising edge of `trstN`. If `cfgSel` is 0, `cfgPin1` is 0 and `cfgPin0` is 1 at that edge, the port runs in full scan mode. For any other pattern the port stays dormant. In dormant mode every instruction behaves as BYPASS and the boundary register is never selected. The mode holds until the next rising edge of `trstN`.

Top module: `gated_tap`

## Requirements
- R1: The controller follows the standard TAP transitions on TMS at each rising TCK edge. Five TCK cycles with TMS high reach Test-Logic-Reset from any state.
- R2: While `trstN` is low, the state machine is held in Test-Logic-Reset and `tdoEn` is low. This takes effect at once, with no TCK edge, and the current instruction becomes IDCODE.
- R3: In Capture-IR the instruction shift register loads 001. It is shifted out LSB first, so the output bits are 1, 0, 0.
- R4: Instruction bits are shifted in LSB first. The opcodes are EXTEST = 000, SAMPLE = 001, IDCODE = 100 and BYPASS = 111. Every other opcode behaves as BYPASS.
- R5: IDCODE selects a 32-bit register. Its value is 0x1B4F402F: version 0x1 in bits 31:28, part 0xB4F4 in bits 27:12, maker 0x017 in bits 11:1, and 1 in bit 0. It is shifted out LSB first.
- R6: The bypass register captures 0 in Capture-DR and delays TDI by exactly one shift.
- R7: Scan mode is decided only at the rising edge of `trstN`, from `cfgSel`=0, `cfgPin1`=0 and `cfgPin0`=1. Later changes on those pins have no effect.
- R8: In dormant mode every opcode, including EXTEST and IDCODE, behaves as BYPASS, and `bsrSelect` and `extestOn` stay low.
- R9: `bsrSelect` is high in scan mode whenever EXTEST or SAMPLE is current. `bsrCapture`, `bsrShift` and `bsrUpdate` go high only with `bsrSelect`, in Capture-DR, Shift-DR and Update-DR respectively. `extestOn` is high only for EXTEST. While the boundary register is shifted, `tdo` carries `bsrTdo`.
- R10: `tdo` and `tdoEn` change on the falling edge of TCK. `tdoEn` is high only while the port is in Shift-IR or Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous active-low test reset; its rising edge latches the mode |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| cfgSel | input | 1 | Mode configuration pin, must be 0 for scan mode |
| cfgPin0 | input | 1 | Mode configuration pin, must be 1 for scan mode |
| cfgPin1 | input | 1 | Mode configuration pin, must be 0 for scan mode |
| bsrTdo | input | 1 | Serial output of the external boundary register |
| tdo | output | 1 | Serial test data out, updated on falling TCK |
| tdoEn | output | 1 | Output enable for tdo |
| bsrSelect | output | 1 | Boundary register is the selected data register |
| bsrCapture | output | 1 | Boundary register capture strobe |
| bsrShift | output | 1 | Boundary register shift strobe |
| bsrUpdate | output | 1 | Boundary register update strobe |
| extestOn | output | 1 | EXTEST is the current instruction in scan mode |

## Verification
A wrong TAP state shows up within one falling TCK edge, because `tdoEn` and the boundary strobes follow the state directly. A corrupted instruction or a wrong mode latch changes `bsrSelect` and `extestOn` in the cycle after Update-IR. A bad capture value or a wrong shift path appears on `tdo` at the first shifted bit. The bench therefore tracks the state, the instruction, the mode and the expected shift contents, and compares `tdo`, `tdoEn` and every strobe on each TCK cycle.

// File: rtl/gated_tap_pkg.sv
package gated_tap_pkg;
  localparam int IR_W = 3;

  typedef enum logic [3:0] {
    sTlr, sRti, sSelDr, sCapDr, sShDr, sEx1Dr, sPauDr, sEx2Dr, sUpdDr,
    sSelIr, sCapIr, sShIr, sEx1Ir, sPauIr, sEx2Ir, sUpdIr
  } tapState_t;

  typedef struct packed {
    logic inReset;
    logic capIr;
    logic shIr;
    logic updIr;
    logic capDr;
    logic shDr;
    logic updDr;
  } tapStrobe_t;

  typedef enum logic [1:0] {pathBypass, pathId, pathBoundary} drPath_t;

  localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 3'b001;
  localparam logic [IR_W-1:0] OP_IDCODE  = 3'b100;
  localparam logic [IR_W-1:0] OP_BYPASS  = 3'b111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;
endpackage

// File: rtl/gated_tap_ctrl.sv
module gated_tap_ctrl
  import gated_tap_pkg::*;
(
  input  logic       tck,
  input  logic       trstN,
  input  logic       tms,
  output tapStrobe_t strobe
);
  tapState_t state, nextState;

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) state <= sTlr;
    else        state <= nextState;
  end

  always_comb begin
    nextState = state;
    unique case (state)
      sTlr:   nextState = tms ? sTlr   : sRti;
      sRti:   nextState = tms ? sSelDr : sRti;
      sSelDr: nextState = tms ? sSelIr : sCapDr;
      sCapDr: nextState = tms ? sEx1Dr : sShDr;
      sShDr:  nextState = tms ? sEx1Dr : sShDr;
      sEx1Dr: nextState = tms ? sUpdDr : sPauDr;
      sPauDr: nextState = tms ? sEx2Dr : sPauDr;
      sEx2Dr: nextState = tms ? sUpdDr : sShDr;
      sUpdDr: nextState = tms ? sSelDr : sRti;
      sSelIr: nextState = tms ? sTlr   : sCapIr;
      sCapIr: nextState = tms ? sEx1Ir : sShIr;
      sShIr:  nextState = tms ? sEx1Ir : sShIr;
      sEx1Ir: nextState = tms ? sUpdIr : sPauIr;
      sPauIr: nextState = tms ? sEx2Ir : sPauIr;
      sEx2Ir: nextState = tms ? sUpdIr : sShIr;
      sUpdIr: nextState = tms ? sSelDr : sRti;
      default: nextState = sTlr;
    endcase
  end

  always_comb begin
    strobe.inReset = (state == sTlr);
    strobe.capIr   = (state == sCapIr);
    strobe.shIr    = (state == sShIr);
    strobe.updIr   = (state == sUpdIr);
    strobe.capDr   = (state == sCapDr);
    strobe.shDr    = (state == sShDr);
    strobe.updDr   = (state == sUpdDr);
  end
endmodule

// File: rtl/gated_tap_data.sv
module gated_tap_data
  import gated_tap_pkg::*;
#(
  parameter int          ID_W    = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h1B4F402F
) (
  input  logic       tck,
  input  logic       trstN,
  input  logic       tdi,
  input  logic       scanMode,
  input  logic       bsrTdo,
  input  tapStrobe_t strobe,
  output logic       tdo,
  output logic       tdoEn,
  output logic       bsrSelect,
  output logic       bsrCapture,
  output logic       bsrShift,
  output logic       bsrUpdate,
  output logic       extestOn
);
  logic [IR_W-1:0] irShift, irReg;
  logic [ID_W-1:0] idShift;
  logic            bypassBit;
  drPath_t         path;
  logic            outBit;

  // instruction shift and hold registers
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      irShift <= IR_CAPTURE;
      irReg   <= OP_IDCODE;
    end else begin
      if (strobe.capIr)     irShift <= IR_CAPTURE;
      else if (strobe.shIr) irShift <= {tdi, irShift[IR_W-1:1]};
      if (strobe.inReset)   irReg <= OP_IDCODE;
      else if (strobe.updIr) irReg <= irShift;
    end
  end

  // instruction decode, gated by the latched mode
  always_comb begin
    path     = pathBypass;
    extestOn = 1'b0;
    if (scanMode) begin
      case (irReg)
        OP_EXTEST: begin path = pathBoundary; extestOn = 1'b1; end
        OP_SAMPLE: path = pathBoundary;
        OP_IDCODE: path = pathId;
        default:   path = pathBypass;
      endcase
    end
  end

  // internal data registers
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      bypassBit <= 1'b0;
      idShift   <= ID_VALUE;
    end else begin
      if (strobe.capDr) begin
        bypassBit <= 1'b0;
        idShift   <= ID_VALUE;
      end else if (strobe.shDr) begin
        bypassBit <= tdi;
        idShift   <= {tdi, idShift[ID_W-1:1]};
      end
    end
  end

  always_comb begin
    if (strobe.shIr) outBit = irShift[0];
    else begin
      case (path)
        pathBoundary: outBit = bsrTdo;
        pathId:       outBit = idShift[0];
        default:      outBit = bypassBit;
      endcase
    end
  end

  // serial output, retimed to the falling edge
  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      tdo   <= 1'b0;
      tdoEn <= 1'b0;
    end else begin
      tdo   <= outBit;
      tdoEn <= strobe.shIr | strobe.shDr;
    end
  end

  assign bsrSelect  = (path == pathBoundary);
  assign bsrCapture = bsrSelect & strobe.capDr;
  assign bsrShift   = bsrSelect & strobe.shDr;
  assign bsrUpdate  = bsrSelect & strobe.updDr;
endmodule

// File: rtl/gated_tap.sv
module gated_tap
  import gated_tap_pkg::*;
#(
  parameter int ID_VER_W  = 4,
  parameter int ID_PART_W = 16,
  parameter int ID_MAKER_W = 11,
  parameter logic [ID_VER_W-1:0]   ID_VER   = 4'h1,
  parameter logic [ID_PART_W-1:0]  ID_PART  = 16'hB4F4,
  parameter logic [ID_MAKER_W-1:0] ID_MAKER = 11'h017
) (
  input  logic tck,
  input  logic trstN,
  input  logic tms,
  input  logic tdi,
  input  logic cfgSel,
  input  logic cfgPin0,
  input  logic cfgPin1,
  input  logic bsrTdo,
  output logic tdo,
  output logic tdoEn,
  output logic bsrSelect,
  output logic bsrCapture,
  output logic bsrShift,
  output logic bsrUpdate,
  output logic extestOn
);
  localparam int ID_W = ID_VER_W + ID_PART_W + ID_MAKER_W + 1;
  localparam logic [ID_W-1:0] ID_VALUE = {ID_VER, ID_PART, ID_MAKER, 1'b1};

  tapStrobe_t strobe;
  logic       scanMode;

  // mode is taken only as the test reset is released
  always_ff @(posedge trstN) begin
    scanMode <= !cfgSel && !cfgPin1 && cfgPin0;
  end

  gated_tap_ctrl uCtrl (
    .tck   (tck),
    .trstN (trstN),
    .tms   (tms),
    .strobe(strobe)
  );

  gated_tap_data #(.ID_W(ID_W), .ID_VALUE(ID_VALUE)) uData (
    .tck       (tck),
    .trstN     (trstN),
    .tdi       (tdi),
    .scanMode  (scanMode),
    .bsrTdo    (bsrTdo),
    .strobe    (strobe),
    .tdo       (tdo),
    .tdoEn     (tdoEn),
    .bsrSelect (bsrSelect),
    .bsrCapture(bsrCapture),
    .bsrShift  (bsrShift),
    .bsrUpdate (bsrUpdate),
    .extestOn  (extestOn)
  );
endmodule

// File: rtl/gated_tap_checker.sv
module gated_tap_checker (
  input logic tck,
  input logic trstN,
  input logic tms,
  input logic scanMode,
  input logic inShift,
  input logic tdoEn,
  input logic bsrSelect,
  input logic bsrCapture,
  input logic bsrShift,
  input logic bsrUpdate
);
  // R8: dormant mode never selects the boundary register
  a_r8_dormant_no_select: assert property (@(posedge tck) disable iff (!trstN)
    !scanMode |-> !bsrSelect);

  // R9: boundary strobes are exclusive and need the select
  a_r9_strobes_exclusive: assert property (@(posedge tck) disable iff (!trstN)
    $onehot0({bsrCapture, bsrShift, bsrUpdate}));

  a_r9_update_needs_select: assert property (@(posedge tck) disable iff (!trstN)
    bsrUpdate |-> bsrSelect);

  // R1: capture with TMS low moves on to shift
  a_r1_capture_to_shift: assert property (@(posedge tck) disable iff (!trstN)
    (bsrCapture && !tms) |=> bsrShift);

  // R1: shift with TMS low stays in shift
  a_r1_shift_holds: assert property (@(posedge tck) disable iff (!trstN)
    (bsrShift && !tms) |=> bsrShift);

  // R10: output enable only in a shift state
  a_r10_enable_in_shift: assert property (@(posedge tck) disable iff (!trstN)
    tdoEn |-> inShift);
endmodule

bind gated_tap gated_tap_checker uChk (
  .tck       (tck),
  .trstN     (trstN),
  .tms       (tms),
  .scanMode  (scanMode),
  .inShift   (strobe.shIr | strobe.shDr),
  .tdoEn     (tdoEn),
  .bsrSelect (bsrSelect),
  .bsrCapture(bsrCapture),
  .bsrShift  (bsrShift),
  .bsrUpdate (bsrUpdate)
);

// File: tb/gated_tap_test.sv
module gated_tap_test;
  localparam int TLR = 0, RTI = 1, SDR = 2, CDR = 3, HDR = 4, E1D = 5, PDR = 6, E2D = 7, UDR = 8;
  localparam int SIR = 9, CIR = 10, HIR = 11, E1I = 12, PIR = 13, E2I = 14, UIR = 15;
  localparam logic [31:0] EXP_ID = {4'b0001, 16'b1011010011110100, 11'b00000010111, 1'b1};

  logic tck = 0;
  logic trstN = 1, tms = 1, tdi = 0;
  logic cfgSel = 0, cfgPin0 = 1, cfgPin1 = 0, bsrTdo = 0;
  logic tdo, tdoEn, bsrSelect, bsrCapture, bsrShift, bsrUpdate, extestOn;

  always #4 tck = ~tck;

  gated_tap uut (.*);

  int nRun = 0, nFail = 0;
  int mSt = TLR;
  bit mMode = 0;
  bit [2:0] mIr = 3'b100;
  bit q[$];

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int nextSt(int s, bit t);
    case (s)
      TLR: return t ? TLR : RTI;
      RTI: return t ? SDR : RTI;
      SDR: return t ? SIR : CDR;
      CDR, HDR: return t ? E1D : HDR;
      E1D: return t ? UDR : PDR;
      PDR: return t ? E2D : PDR;
      E2D: return t ? UDR : HDR;
      UDR, UIR: return t ? SDR : RTI;
      SIR: return t ? TLR : CIR;
      CIR, HIR: return t ? E1I : HIR;
      E1I: return t ? UIR : PIR;
      PIR: return t ? E2I : PIR;
      E2I: return t ? UIR : HIR;
      default: return TLR;
    endcase
  endfunction

  // 0 bypass, 1 id, 2 boundary
  function automatic int mPath();
    if (!mMode) return 0;
    if (mIr == 3'b000 || mIr == 3'b001) return 2;
    if (mIr == 3'b100) return 1;
    return 0;
  endfunction

  task automatic tick(bit t, bit d, output bit o);
    bit expEn, sel, expBit;
    tms = t; tdi = d; bsrTdo = $urandom_range(0, 1);
    @(negedge tck); #1;
    expEn = (mSt == HDR || mSt == HIR);
    sel = (mPath() == 2);
    chk(tdoEn === expEn, "R10 tdoEn", tdoEn, expEn);
    if (expEn) begin
      expBit = (mSt == HDR && mPath() == 2) ? bsrTdo : q[0];
      chk(tdo === expBit, "R10 tdo bit", tdo, expBit);
    end
    chk(bsrSelect === sel, "R9 bsrSelect", bsrSelect, sel);
    chk(bsrCapture === (sel && mSt == CDR), "R9 bsrCapture", bsrCapture, sel && mSt == CDR);
    chk(bsrShift === (sel && mSt == HDR), "R9 bsrShift", bsrShift, sel && mSt == HDR);
    chk(bsrUpdate === (sel && mSt == UDR), "R9 bsrUpdate", bsrUpdate, sel && mSt == UDR);
    chk(extestOn === (sel && mIr == 3'b000), "R9 extestOn", extestOn, sel && mIr == 3'b000);
    o = tdo;
    @(posedge tck);
    case (mSt)
      TLR: mIr = 3'b100;
      CIR: begin q.delete(); q.push_back(1); q.push_back(0); q.push_back(0); end
      HIR: begin void'(q.pop_front()); q.push_back(d); end
      UIR: mIr = {q[2], q[1], q[0]};
      CDR: begin
        q.delete();
        if (mPath() == 1) for (int i = 0; i < 32; i++) q.push_back(EXP_ID[i]);
        else if (mPath() == 0) q.push_back(0);
      end
      HDR: if (mPath() != 2) begin void'(q.pop_front()); q.push_back(d); end
      default: ;
    endcase
    mSt = nextSt(mSt, t);
    #1;
  endtask

  task automatic loadIr(bit [2:0] op);
    bit o;
    bit [2:0] cap;
    tick(1, 0, o); tick(1, 0, o); tick(0, 0, o); tick(0, 0, o);
    for (int i = 0; i < 3; i++) begin
      tick(i == 2, op[i], o);
      cap[i] = o;
    end
    chk(cap === 3'b001, "R3 capture value", cap, 3'b001);
    tick(1, 0, o); tick(0, 0, o);
  endtask

  task automatic scanDr(int n, bit [31:0] din, output bit [31:0] dout);
    bit o;
    dout = 0;
    tick(1, 0, o); tick(0, 0, o); tick(0, 0, o);
    for (int i = 0; i < n; i++) begin
      tick(i == n - 1, din[i], o);
      dout[i] = o;
    end
    tick(1, 0, o); tick(0, 0, o);
  endtask

  task automatic doReset(bit s, bit p1, bit p0);
    trstN = 0; cfgSel = s; cfgPin1 = p1; cfgPin0 = p0;
    #1;
    chk(tdoEn === 1'b0, "R2 async tdoEn low", tdoEn, 0);
    mSt = TLR; mIr = 3'b100; q.delete();
    #1 trstN = 1;
    mMode = !s && !p1 && p0;
    #1 cfgSel = ~s; cfgPin1 = ~p1; cfgPin0 = ~p0;
  endtask

  initial begin
    #1000000;
    nRun++; nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    bit [31:0] d;
    bit o;
    #1 trstN = 0;
    #30;
    chk(tdoEn === 1'b0, "R2 reset tdoEn", tdoEn, 0);
    chk(tdo === 1'b0, "R2 reset tdo", tdo, 0);
    @(posedge tck); #1;
    doReset(0, 0, 1);
    tick(0, 0, o);
    scanDr(32, 32'h0, d);
    chk(d === EXP_ID, "R5 idcode after reset", d, EXP_ID);

    loadIr(3'b111);
    scanDr(8, 32'hA5, d);
    chk(d[0] === 1'b0, "R6 bypass captures 0", d[0], 0);
    chk(d[7:1] === 7'h25, "R6 bypass one-bit delay", d[7:1], 7'h25);

    loadIr(3'b000);
    chk(bsrSelect === 1 && extestOn === 1, "R9 extest select", {bsrSelect, extestOn}, 2'b11);
    scanDr(6, 32'h2B, d);

    loadIr(3'b001);
    chk(bsrSelect === 1 && extestOn === 0, "R9 sample select", {bsrSelect, extestOn}, 2'b10);
    scanDr(5, 32'h11, d);

    loadIr(3'b010);
    scanDr(4, 32'hB, d);
    chk(d[3:0] === 4'b0110, "R4 unlisted opcode is bypass", d[3:0], 4'b0110);

    loadIr(3'b100);
    scanDr(32, 32'hFFFF0000, d);
    chk(d === EXP_ID, "R4 idcode opcode", d, EXP_ID);

    loadIr(3'b000);
    tick(1, 0, o); tick(0, 0, o); tick(0, 0, o);
    for (int i = 0; i < 5; i++) tick(1, 0, o);
    tick(0, 0, o);
    chk(bsrSelect === 0, "R1 five TMS high reset", bsrSelect, 0);
    scanDr(32, 32'h0, d);
    chk(d === EXP_ID, "R1 idcode after TMS reset", d, EXP_ID);

    loadIr(3'b111);
    tick(1, 0, o); tick(0, 0, o); tick(0, 0, o);
    @(negedge tck); #1;
    chk(tdoEn === 1'b1, "R10 enable in shift", tdoEn, 1);
    doReset(1, 0, 1);
    tick(0, 0, o);
    loadIr(3'b000);
    chk(bsrSelect === 0 && extestOn === 0, "R8 dormant extest", {bsrSelect, extestOn}, 0);
    scanDr(4, 32'h5, d);
    chk(d[3:0] === 4'b1010, "R8 dormant extest bypass", d[3:0], 4'b1010);
    loadIr(3'b100);
    scanDr(4, 32'h3, d);
    chk(d[3:0] === 4'b0110, "R8 dormant idcode bypass", d[3:0], 4'b0110);

    doReset(0, 1, 1);
    tick(0, 0, o);
    loadIr(3'b001);
    chk(bsrSelect === 0, "R7 pin1 high dormant", bsrSelect, 0);
    doReset(0, 0, 0);
    tick(0, 0, o);
    loadIr(3'b001);
    chk(bsrSelect === 0, "R7 pin0 low dormant", bsrSelect, 0);

    doReset(0, 0, 1);
    tick(0, 0, o);
    loadIr(3'b000);
    chk(bsrSelect === 1, "R7 later pin change ignored", bsrSelect, 1);
    scanDr(3, 32'h6, d);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule